// File: doc/BRIEF.md
# Link Cell Stuffing Scheduler

This block tells every link of an inverse-multiplexed link group when to send a stuff event. A stuff event is one extra control cell that takes up the rate difference between links. Each link has its own counter. The counter advances on every cell the link puts on the wire, whether that cell is a control, filler or data cell. When a link reaches the end of its period, the block raises that link's stuff request in the same cycle as the cell strobe that completed the period. The transmit path then inserts the extra cell. Building that cell is not part of this block.

There are two clocking modes. In common-clock mode all links share one transmit clock, and each link stuffs once per 2048 cells. In independent-clock mode only the selected reference link keeps that fixed pace. The other links each keep a signed offset accumulator. A link-fast indication adds one to it, and every stuff on the reference link takes one away. A non-reference link stuffs at its own period boundary only when its accumulator is above zero. It also stuffs on extra cells whenever the accumulator rises above a threshold. Moving the reference to another link clears all accumulators.

Top module: `link_stuff_sched`

## Requirements
- R1: Each link's counter advances only on cycles where that link's `cell_sent` bit is high, and idle cycles leave it unchanged. The 2048th strobe ends the period, and the count then starts again from zero.
- R2: A stuff request is a pulse of one cycle. It is high only in the same cycle as a strobe on that link, and never in two cycles in a row.
- R3: With `indep_mode` = 0, every link requests a stuff on the strobe that ends each of its 2048-cell periods.
- R4: With `indep_mode` = 1, the link whose index equals `ref_sel` requests a stuff on the strobe that ends each of its 2048-cell periods.
- R5: With `indep_mode` = 1, a non-reference link requests a stuff at its own period boundary only if its offset accumulator is above zero. The accumulator is signed. It goes up by one on each cycle that the link's `fast_ind` bit is high, and down by one on each stuff issued by the reference link.
- R6: With `indep_mode` = 1, a non-reference link whose accumulator is above THRESH (default 8) requests an extra stuff on its next allowed strobe. Each such extra stuff takes one from its accumulator.
- R7: A link never issues stuffs on two consecutive strobes. A period-boundary stuff that this rule blocks is issued on the link's next strobe.
- R8: Any change of `ref_sel` clears the offset accumulators of all links to zero.
- R9: While reset is asserted, and after it, all counters and accumulators are zero and no stuff request is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cell_sent | input | NLINKS | Per-link strobe: one cell sent on that link this cycle |
| ref_sel | input | IDX_W | Index of the timing reference link |
| indep_mode | input | 1 | 0 = common transmit clock, 1 = independent clocks |
| fast_ind | input | NLINKS | Per-link indication that the link runs fast against the reference |
| stuff_req | output | NLINKS | Per-link stuff request, aligned with that link's cell strobe |

## Verification
The hardest case to reach from the ports is a period-boundary stuff that collides with an extra stuff on the strobe just before it, so that the boundary stuff has to wait one strobe. The stimulus keeps the reference link silent, which stops the accumulator from draining. It then raises `fast_ind` on exactly nine strobes of one non-reference link, so that the accumulator first passes the threshold on the 2047th strobe. The bench then checks that stuffs land on strobes 2047 and 2049 but not on strobe 2048. A second directed case changes `ref_sel` after an offset has built up, and shows that a boundary stuff which would otherwise occur no longer happens.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

  typedef enum logic {
    MODE_COMMON = 1'b0,
    MODE_INDEP  = 1'b1
  } clk_mode_e;

  typedef enum logic [1:0] {
    SR_NONE     = 2'd0,
    SR_BOUNDARY = 2'd1,
    SR_EXTRA    = 2'd2
  } stuff_reason_e;

endpackage

// File: rtl/lcs_cell_counter.sv
module lcs_cell_counter #(
  parameter int PERIOD = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cell_i,
  output logic boundary_o
);

  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d      = cnt_q;
    boundary_o = 1'b0;
    if (cell_i) begin
      if (cnt_q == LAST) begin
        cnt_d      = '0;
        boundary_o = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cell_i)  cnt_q <= cnt_d;
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_i |=> $stable(cnt_q));

  // R1
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/lcs_offset_acc.sv
module lcs_offset_acc #(
  parameter int ACC_W  = 6,
  parameter int THRESH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic inc_i,
  input  logic dec_ref_i,
  input  logic dec_extra_i,
  output logic positive_o,
  output logic excess_o
);

  localparam int SW = ACC_W + 2;
  localparam logic signed [SW-1:0]    SMAX = SW'((1 << (ACC_W - 1)) - 1);
  localparam logic signed [SW-1:0]    SMIN = -SW'(1 << (ACC_W - 1));
  localparam logic signed [ACC_W-1:0] AMAX = ACC_W'((1 << (ACC_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] THR  = ACC_W'(THRESH);

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [SW-1:0]    sum;

  always_comb begin
    sum = SW'(acc_q) + SW'(inc_i) - SW'(dec_ref_i) - SW'(dec_extra_i);
    if (clear_i)          acc_d = '0;
    else if (sum > SMAX)  acc_d = AMAX;
    else if (sum < SMIN)  acc_d = ACC_W'(SMIN);
    else                  acc_d = ACC_W'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign positive_o = (acc_q > 0);
  assign excess_o   = (acc_q > THR);

  // R8
  ref_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (acc_q == '0));

  // R5
  fast_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && inc_i && !dec_ref_i && !dec_extra_i && acc_q != AMAX)
      |=> (acc_q == $past(acc_q) + ACC_W'(1)));

endmodule

// File: rtl/lcs_stuff_gate.sv
module lcs_stuff_gate
  import lcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cell_i,
  input  logic boundary_i,
  input  logic periodic_en_i,
  input  logic extra_i,
  output logic stuff_o,
  output logic extra_taken_o
);

  logic last_q, last_d;
  logic pend_q, pend_d;
  logic want_bnd;
  stuff_reason_e reason;

  always_comb begin
    want_bnd = boundary_i && periodic_en_i;
    if (pend_q || want_bnd) reason = SR_BOUNDARY;
    else if (extra_i)       reason = SR_EXTRA;
    else                    reason = SR_NONE;

    stuff_o       = cell_i && !last_q && (reason != SR_NONE);
    extra_taken_o = stuff_o && (reason == SR_EXTRA);

    last_d = last_q;
    pend_d = pend_q;
    if (cell_i) begin
      last_d = stuff_o;
      pend_d = last_q && (pend_q || want_bnd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      last_q <= last_d;
      pend_q <= pend_d;
    end
  end

  // R7
  spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_i && last_q) |-> !stuff_o);

endmodule

// File: rtl/link_stuff_sched.sv
module link_stuff_sched
  import lcs_pkg::*;
#(
  parameter int NLINKS = 4,
  parameter int PERIOD = 2048,
  parameter int ACC_W  = 6,
  parameter int THRESH = 8,
  localparam int IDX_W = (NLINKS > 1) ? $clog2(NLINKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINKS-1:0] cell_sent,
  input  logic [IDX_W-1:0]  ref_sel,
  input  logic              indep_mode,
  input  logic [NLINKS-1:0] fast_ind,
  output logic [NLINKS-1:0] stuff_req
);

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [IDX_W-1:0]  ref_q;
  logic              ref_chg;
  logic [NLINKS-1:0] ref_onehot;
  logic              ref_stuff;
  clk_mode_e         mode;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ref_q <= '0;
    else             ref_q <= ref_sel;
  end

  assign ref_chg   = (ref_sel != ref_q);
  assign mode      = clk_mode_e'(indep_mode);
  assign ref_stuff = |(stuff_req & ref_onehot);

  logic [NLINKS-1:0] bnd, pos, exc, extra_taken, periodic_en, extra_en;

  for (genvar i = 0; i < NLINKS; i++) begin : g_link
    assign ref_onehot[i]  = (ref_sel == IDX_W'(i));
    assign periodic_en[i] = (mode == MODE_COMMON) || ref_onehot[i] || pos[i];
    assign extra_en[i]    = (mode == MODE_INDEP) && !ref_onehot[i] && exc[i];

    lcs_cell_counter #(.PERIOD(PERIOD)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .cell_i     (cell_sent[i]),
      .boundary_o (bnd[i])
    );

    lcs_offset_acc #(.ACC_W(ACC_W), .THRESH(THRESH)) u_acc (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .clear_i     (ref_chg),
      .inc_i       (fast_ind[i]),
      .dec_ref_i   (ref_stuff),
      .dec_extra_i (extra_taken[i]),
      .positive_o  (pos[i]),
      .excess_o    (exc[i])
    );

    lcs_stuff_gate u_gate (
      .clk           (clk),
      .rst_n         (rst_sync_n),
      .cell_i        (cell_sent[i]),
      .boundary_i    (bnd[i]),
      .periodic_en_i (periodic_en[i]),
      .extra_i       (extra_en[i]),
      .stuff_o       (stuff_req[i]),
      .extra_taken_o (extra_taken[i])
    );

    // R3
    common_period_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!indep_mode && bnd[i]) |-> stuff_req[i]);

    // R4
    ref_period_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (indep_mode && ref_onehot[i] && bnd[i]) |-> stuff_req[i]);

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      stuff_req[i] |=> !stuff_req[i]);
  end

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (stuff_req == '0));

endmodule

// File: tb/link_stuff_sched_test.sv
`timescale 1ns/1ps
module link_stuff_sched_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] cell_sent;
  logic [1:0] ref_sel;
  logic       indep_mode;
  logic [3:0] fast_ind;
  logic [3:0] stuff_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  link_stuff_sched uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_sent  (cell_sent),
    .ref_sel    (ref_sel),
    .indep_mode (indep_mode),
    .fast_ind   (fast_ind),
    .stuff_req  (stuff_req)
  );

  typedef struct packed {
    logic             indep;
    logic [1:0]       refl;
    logic [12:0]      ncells;
    logic [3:0]       fmask;
    logic [4:0]       fcnt;
    logic [3:0][2:0]  exp;
    logic [7:0]       req;
  } vec_t;

  // exp holds the per-link stuff count, link 3 first; req is the requirement number
  localparam vec_t VEC [0:7] = '{
    '{1'b0, 2'd0, 13'd2048, 4'h0, 5'd0,  {3'd1,3'd1,3'd1,3'd1}, 8'd3},
    '{1'b0, 2'd1, 13'd4095, 4'h0, 5'd0,  {3'd1,3'd1,3'd1,3'd1}, 8'd3},
    '{1'b0, 2'd0, 13'd4096, 4'h0, 5'd0,  {3'd2,3'd2,3'd2,3'd2}, 8'd3},
    '{1'b1, 2'd0, 13'd2048, 4'h0, 5'd0,  {3'd0,3'd0,3'd0,3'd1}, 8'd4},
    '{1'b1, 2'd2, 13'd2047, 4'h0, 5'd0,  {3'd0,3'd0,3'd0,3'd0}, 8'd4},
    '{1'b1, 2'd0, 13'd2048, 4'h2, 5'd3,  {3'd0,3'd0,3'd1,3'd1}, 8'd5},
    '{1'b1, 2'd0, 13'd100,  4'h4, 5'd12, {3'd0,3'd4,3'd0,3'd0}, 8'd6},
    '{1'b1, 2'd3, 13'd4096, 4'h1, 5'd1,  {3'd2,3'd0,3'd0,3'd1}, 8'd5}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] cs, input logic [3:0] fi,
                      output logic [3:0] st);
    @(negedge clk);
    cell_sent = cs;
    fast_ind  = fi;
    #1;
    st = stuff_req;
  endtask

  task automatic do_reset(input logic md, input logic [1:0] rl);
    @(negedge clk);
    rst_n      = 1'b0;
    cell_sent  = '0;
    fast_ind   = '0;
    indep_mode = md;
    ref_sel    = rl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] st;
    int cnt [4];
    int viol;
    logic [3:0] prev;

    rst_n      = 1'b0;
    cell_sent  = '0;
    fast_ind   = '0;
    indep_mode = 1'b0;
    ref_sel    = '0;

    // R9: reset state
    do_reset(1'b0, 2'd0);
    step(4'h0, 4'h0, st);
    check(st == 4'h0, "R9", "stuff_req after reset", st, 0);

    // table walk
    for (int v = 0; v < 8; v++) begin
      do_reset(VEC[v].indep, VEC[v].refl);
      for (int k = 0; k < 4; k++) cnt[k] = 0;
      viol = 0;
      prev = '0;
      for (int n = 0; n < int'(VEC[v].ncells); n++) begin
        step(4'hF, (n < int'(VEC[v].fcnt)) ? VEC[v].fmask : 4'h0, st);
        for (int k = 0; k < 4; k++) if (st[k]) cnt[k]++;
        if ((st & prev) != 4'h0) viol++;
        prev = st;
      end
      step(4'h0, 4'h0, st);
      for (int k = 0; k < 4; k++)
        check(cnt[k] == int'(VEC[v].exp[k]), $sformatf("R%0d", VEC[v].req),
              $sformatf("vector %0d link %0d stuff count", v, k),
              cnt[k], int'(VEC[v].exp[k]));
      // R7: consecutive strobes never both stuff
      check(viol == 0, "R7", $sformatf("vector %0d back-to-back stuffs", v), viol, 0);
    end

    // R1 and R2: strobes interleaved with idle cycles on link 0 only
    do_reset(1'b0, 2'd0);
    viol = 0;
    for (int n = 0; n < 2047; n++) begin
      step(4'h1, 4'h0, st);
      if (st != 4'h0) viol++;
      step(4'h0, 4'h0, st);
      if (st != 4'h0) viol++;
    end
    check(viol == 0, "R1", "early or idle-cycle stuff", viol, 0);
    step(4'h1, 4'h0, st);
    check(st == 4'h1, "R2", "stuff on 2048th strobe", st, 1);
    step(4'h0, 4'h0, st);
    check(st == 4'h0, "R2", "stuff after pulse", st, 0);
    viol = 0;
    for (int n = 0; n < 2047; n++) begin
      step(4'h1, 4'h0, st);
      if (st != 4'h0) viol++;
    end
    check(viol == 0, "R1", "stuff before restarted period ends", viol, 0);
    step(4'h1, 4'h0, st);
    check(st == 4'h1, "R1", "stuff at end of second period", st, 1);

    // R9: reset in mid-period restarts the count
    do_reset(1'b0, 2'd0);
    for (int n = 0; n < 2000; n++) step(4'h1, 4'h0, st);
    do_reset(1'b0, 2'd0);
    cnt[0] = 0;
    viol = -1;
    for (int n = 0; n < 2048; n++) begin
      step(4'h1, 4'h0, st);
      if (st[0]) begin cnt[0]++; viol = n; end
    end
    check(cnt[0] == 1 && viol == 2047, "R9", "strobe index of stuff after reset", viol, 2047);

    // R8: reference change clears built-up offset
    do_reset(1'b1, 2'd0);
    for (int n = 0; n < 5; n++) step(4'hF, 4'h2, st);
    ref_sel = 2'd3;
    step(4'h0, 4'h0, st);
    for (int k = 0; k < 4; k++) cnt[k] = 0;
    for (int n = 0; n < 2048; n++) begin
      step(4'hF, 4'h0, st);
      for (int k = 0; k < 4; k++) if (st[k]) cnt[k]++;
    end
    check(cnt[1] == 0, "R8", "link 1 stuffs after reference change", cnt[1], 0);
    check(cnt[3] == 1, "R4", "new reference link 3 stuffs", cnt[3], 1);

    // R7: boundary stuff deferred behind an extra stuff on link 1
    do_reset(1'b1, 2'd0);
    cnt[1] = 0;
    viol = 0;
    for (int n = 0; n <= 2048; n++) begin
      step(4'h2, (n >= 2037 && n <= 2045) ? 4'h2 : 4'h0, st);
      if (st[1]) cnt[1]++;
      if (n == 2045) check(st[1] == 1'b0, "R6", "no stuff at threshold", st[1], 0);
      if (n == 2046) check(st[1] == 1'b1, "R6", "extra stuff above threshold", st[1], 1);
      if (n == 2047) check(st[1] == 1'b0, "R7", "boundary stuff blocked", st[1], 0);
      if (n == 2048) check(st[1] == 1'b1, "R7", "deferred boundary stuff", st[1], 1);
    end
    check(cnt[1] == 2, "R5", "total stuffs on link 1", cnt[1], 2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule